// File: doc/BRIEF.md
# I2C Slave Address Matcher with Masking

This block is the address front end of an I2C slave. It watches the bus, finds START and STOP conditions, and shifts in the address byte (7-bit addressing) or the two address bytes (10-bit addressing) after each START. It compares the received address with a programmable own address. Any bit whose mask bit is set is left out of the comparison. It then decides whether to pull SDA low on the ninth clock.

Two masking schemes are offered:

- **Coarse scheme.** A 5-bit control covers a fixed group of own-address bits. Its lowest bit reaches one or two address bits, depending on the addressing mode.
- **Full scheme.** An 8-bit register gives one mask bit per own-address position.

The all-zero address is treated as a general call and is accepted only when enabled. Once an address is accepted, the block raises a match or general-call flag and pulses an interrupt. If stretching is enabled, it holds SCL low until the surrounding logic releases it.

The own address is given in received-byte positions. In 7-bit addressing the address occupies `own_addr[7:1]`, and bits 9:8 and 0 are not used. In 10-bit addressing `own_addr[9:8]` are the high bits and `own_addr[7:0]` the low byte.

Top module: `i2c_addr_match`

## Requirements
- R1: SDA and SCL pass through a two-flop synchroniser. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bits clocked without a preceding START are ignored (no ACK). STOP clears `match`, `gc_hit` and `rw`. After reset `sda_low`, `scl_low`, `match`, `gc_hit` and `irq` are 0.
- R2: In 7-bit addressing (`addr10`=0), bits 7:1 of the first byte after START are the address and bit 0 is R/W (1 = read). SDA is pulled low during the ninth clock only when the address field is nonzero and equals `own_addr[7:1]` on every unmasked bit. On acceptance `match`=1 and `rw` equals byte bit 0.
- R3: A first byte of 0x00 is a general call. With `gc_en`=1 it is acknowledged, `gc_hit` rises and `irq` pulses, while `match` stays 0. With `gc_en`=0 it gets no ACK and no flag.
- R4: Full scheme (`mask_mode`=1): mask register bit k masks own-address position k for k = 7..0, and positions 9:8 are never masked. In 7-bit addressing bit 0 has no effect on the address comparison.
- R5: Coarse scheme (`mask_mode`=0): coarse bits 4:1 mask own-address positions 5:2. In 7-bit addressing coarse bit 0 masks position 1 only.
- R6: Coarse scheme in 10-bit addressing: coarse bit 0 masks positions 1 and 0 together.
- R7: The full mask register resets to 0xFF and the coarse control resets to 0. Both load from `cfg_mask_full` and `cfg_mask_coarse` on a cycle with `cfg_load`=1 and keep their values otherwise.
- R8: In 10-bit addressing, the first byte 11110,A9,A8,0 is acknowledged when A9:A8 equal `own_addr[9:8]`, and `match` stays 0. The second byte is then compared under the mask with `own_addr[7:0]`. `match` is declared and ACK given only if that comparison holds.
- R9: A repeated START restarts address reception from the first byte without a STOP.
- R10: With `stretch_en`=1, after an accepted address is acknowledged, `scl_low` is asserted from the end of the ninth clock until a `hold_release` pulse. With `stretch_en`=0, `scl_low` is never asserted.
- R11: `irq` is a single-cycle pulse for each accepted address (a final match or an accepted general call).
- R12: After a full 10-bit match, a repeated START followed by first byte 11110,A9,A8,1 with matching high bits is acknowledged with `match`=1 and `rw`=1. After a STOP this read form is no longer acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| own_addr | input | 10 | Own address in received-byte positions |
| cfg_load | input | 1 | Load strobe for both mask registers |
| cfg_mask_full | input | 8 | New value for the full mask register |
| cfg_mask_coarse | input | 5 | New value for the coarse mask control |
| mask_mode | input | 1 | 0 = coarse scheme, 1 = full scheme |
| addr10 | input | 1 | 1 = 10-bit addressing |
| gc_en | input | 1 | Accept the general call |
| stretch_en | input | 1 | Allow SCL hold after acceptance |
| hold_release | input | 1 | Pulse that ends an SCL hold |
| sda_low | output | 1 | Pull SDA low (ACK) |
| scl_low | output | 1 | Pull SCL low (stretch) |
| match | output | 1 | Own address accepted |
| gc_hit | output | 1 | General call accepted |
| rw | output | 1 | R/W bit of the accepted address |
| irq | output | 1 | One-cycle pulse on acceptance |

## Verification
The assertions check the following on every cycle:

- No SCL hold occurs while stretching is disabled or without an accepted address.
- A general-call flag never exists with the enable clear.
- `match` and `gc_hit` are never both set.
- The interrupt is a lone pulse that comes with a flag.
- The mask registers keep their value without a load.
- ACK drive begins only while SCL is low.

Only the bench scenarios can show whether the ACK decision is right. That covers which address bits each mask scheme covers, the reset values of the masks, the two-byte 10-bit sequence and its read form after a repeated START, and whether bits clocked without a START are ignored.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [9:0] own_addr,
  input  logic       cfg_load,
  input  logic [7:0] cfg_mask_full,
  input  logic [4:0] cfg_mask_coarse,
  input  logic       mask_mode,
  input  logic       addr10,
  input  logic       gc_en,
  input  logic       stretch_en,
  input  logic       hold_release,
  output logic       sda_low,
  output logic       scl_low,
  output logic       match,
  output logic       gc_hit,
  output logic       rw,
  output logic       irq
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR1, S_ADDR2, S_ACK, S_DONE, S_SKIP} st_t;

  logic [1:0] scl_sync, sda_sync;
  logic       scl_p, sda_p;
  logic [7:0] mask_full;
  logic [4:0] mask_coarse;
  logic [9:0] ign;
  st_t        st;
  logic [2:0] cnt;
  logic [6:0] shreg;
  logic       ack_q, fin_q, drive, armed, hold_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_p    <= scl_sync[1];
      sda_p    <= sda_sync[1];
    end

  wire scl_s     = scl_sync[1];
  wire sda_s     = sda_sync[1];
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_full   <= 8'hFF;
      mask_coarse <= 5'h00;
    end else if (cfg_load) begin
      mask_full   <= cfg_mask_full;
      mask_coarse <= cfg_mask_coarse;
    end

  always_comb begin
    ign = '0;
    if (mask_mode) ign[7:0] = mask_full;
    else begin
      ign[5:2] = mask_coarse[4:1];
      ign[1]   = mask_coarse[0];
      ign[0]   = mask_coarse[0] & addr10;
    end
  end

  wire [7:0] byte_w = {shreg, sda_s};
  wire is_gc  = byte_w == 8'h00;
  wire cmp7   = (byte_w[7:1] != 7'd0) &&
                (((byte_w[7:1] ^ own_addr[7:1]) & ~ign[7:1]) == 7'd0);
  wire hi_ok  = (byte_w[7:3] == 5'b11110) && (byte_w[2:1] == own_addr[9:8]);
  wire lo_ok  = ((byte_w ^ own_addr[7:0]) & ~ign[7:0]) == 8'd0;
  wire last   = scl_rise && (cnt == 3'd7);

  assign scl_low = hold_q & stretch_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      ack_q   <= 1'b0;
      fin_q   <= 1'b0;
      drive   <= 1'b0;
      sda_low <= 1'b0;
      match   <= 1'b0;
      gc_hit  <= 1'b0;
      rw      <= 1'b0;
      irq     <= 1'b0;
      armed   <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (hold_release) hold_q <= 1'b0;
      if (start_det || stop_det) begin
        st      <= start_det ? S_ADDR1 : S_IDLE;
        cnt     <= '0;
        drive   <= 1'b0;
        sda_low <= 1'b0;
        match   <= 1'b0;
        gc_hit  <= 1'b0;
        rw      <= 1'b0;
        hold_q  <= 1'b0;
        if (stop_det) armed <= 1'b0;
      end else begin
        case (st)
          S_ADDR1, S_ADDR2: if (scl_rise) begin
            shreg <= byte_w[6:0];
            cnt   <= cnt + 3'd1;
            if (last) begin
              st    <= S_ACK;
              fin_q <= 1'b1;
              if (st == S_ADDR2) begin
                ack_q <= lo_ok;
                match <= lo_ok;
                armed <= lo_ok;
                rw    <= 1'b0;
                irq   <= lo_ok;
              end else if (is_gc) begin
                ack_q  <= gc_en;
                gc_hit <= gc_en;
                irq    <= gc_en;
              end else if (!addr10) begin
                ack_q <= cmp7;
                match <= cmp7;
                rw    <= byte_w[0];
                irq   <= cmp7;
              end else if (hi_ok && !byte_w[0]) begin
                ack_q <= 1'b1;
                fin_q <= 1'b0;
              end else if (hi_ok && armed) begin
                ack_q <= 1'b1;
                match <= 1'b1;
                rw    <= 1'b1;
                irq   <= 1'b1;
              end else begin
                ack_q <= 1'b0;
              end
            end
          end
          S_ACK: if (scl_fall) begin
            if (!drive) begin
              drive   <= 1'b1;
              sda_low <= ack_q;
            end else begin
              drive   <= 1'b0;
              sda_low <= 1'b0;
              if (!ack_q) st <= S_SKIP;
              else if (!fin_q) begin
                st  <= S_ADDR2;
                cnt <= '0;
              end else begin
                st     <= S_DONE;
                hold_q <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end

endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       gc_en,
  input logic       stretch_en,
  input logic       cfg_load,
  input logic [7:0] mask_full,
  input logic [4:0] mask_coarse,
  input logic       sda_low,
  input logic       scl_low,
  input logic       match,
  input logic       gc_hit,
  input logic       irq
);

  a_r10_no_stretch_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !stretch_en |-> !scl_low);

  a_r10_hold_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    scl_low |-> (match || gc_hit));

  a_r3_gc_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    gc_hit |-> gc_en);

  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(match && gc_hit));

  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r11_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (match || gc_hit));

  a_r7_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(mask_full) && $stable(mask_coarse)));

  a_r2_ack_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> !scl_in);

endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .gc_en(gc_en),
  .stretch_en(stretch_en), .cfg_load(cfg_load), .mask_full(mask_full),
  .mask_coarse(mask_coarse), .sda_low(sda_low), .scl_low(scl_low),
  .match(match), .gc_hit(gc_hit), .irq(irq)
);

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, scl_m, sda_m;
  logic [9:0] own_addr;
  logic       cfg_load;
  logic [7:0] cfg_mask_full;
  logic [4:0] cfg_mask_coarse;
  logic       mask_mode, addr10, gc_en, stretch_en, hold_release;
  logic       sda_low, scl_low, match, gc_hit, rw, irq;

  wire scl_line = scl_m & ~scl_low;
  wire sda_line = sda_m & ~sda_low;

  i2c_addr_match dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .own_addr(own_addr), .cfg_load(cfg_load), .cfg_mask_full(cfg_mask_full),
    .cfg_mask_coarse(cfg_mask_coarse), .mask_mode(mask_mode), .addr10(addr10),
    .gc_en(gc_en), .stretch_en(stretch_en), .hold_release(hold_release),
    .sda_low(sda_low), .scl_low(scl_low), .match(match), .gc_hit(gc_hit),
    .rw(rw), .irq(irq)
  );

  localparam int Q = 8;
  int  total = 0, bad = 0, irq_cnt = 0;
  bit  done = 1'b0;
  logic [7:0] cur_mf = 8'hFF;
  logic [4:0] cur_mc = 5'h00;

  always @(posedge clk) if (rst_n && irq) irq_cnt++;

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] ign_f(input logic mode, input logic a10, input logic [7:0] mf, input logic [4:0] mc);
    logic [9:0] r = '0;
    if (mode) r[7:0] = mf;
    else begin
      r[5:2] = mc[4:1];
      r[1]   = mc[0];
      r[0]   = mc[0] & a10;
    end
    return r;
  endfunction

  function automatic bit e_ack7(input logic [7:0] b, input logic [9:0] own, input logic [9:0] ig, input logic gce);
    if (b == 8'h00) return gce;
    return (b[7:1] != 7'd0) && (((b[7:1] ^ own[7:1]) & ~ig[7:1]) == 7'd0);
  endfunction

  task automatic load(input logic [7:0] mf, input logic [4:0] mc);
    cfg_mask_full = mf; cfg_mask_coarse = mc; cfg_load = 1'b1;
    w(1);
    cfg_load = 1'b0;
    cur_mf = mf; cur_mc = mc;
    w(1);
  endtask

  task automatic start_c();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    ack = !sda_line;
    w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic one7(input string req, input logic [7:0] b, input bit eack, input bit egc);
    bit a;
    irq_cnt = 0;
    start_c();
    send(b, a);
    chk(req, "ack", 32'(a), 32'(eack));
    chk(req, "match", 32'(match), 32'(eack && !egc));
    chk(req, "gc_hit", 32'(gc_hit), 32'(egc));
    chk(req, "irq", 32'(irq_cnt), 32'(eack));
    if (eack && !egc) chk(req, "rw", 32'(rw), 32'(b[0]));
    stop_c();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [9:0] ig;
    logic [7:0] b, b2, flip;
    logic [1:0] hf;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; cfg_load = 1'b0;
    cfg_mask_full = '0; cfg_mask_coarse = '0; hold_release = 1'b0;
    mask_mode = 1'b1; addr10 = 1'b0; gc_en = 1'b0; stretch_en = 1'b0;
    own_addr = 10'h0A4;
    w(5);
    rst_n = 1'b1;
    w(3);
    chk("R1", "reset sda_low", 32'(sda_low), 0);
    chk("R1", "reset scl_low", 32'(scl_low), 0);
    chk("R1", "reset match", 32'(match), 0);
    chk("R1", "reset gc_hit", 32'(gc_hit), 0);
    chk("R1", "reset irq", 32'(irq), 0);

    // R7: full mask resets to all ones, so any nonzero address is accepted
    one7("R7", 8'h3C, 1'b1, 1'b0);
    // R7: coarse control resets to zero, exact compare
    mask_mode = 1'b0;
    one7("R7", 8'h3C, 1'b0, 1'b0);
    one7("R2", 8'hA4, 1'b1, 1'b0);
    one7("R2", 8'hA5, 1'b1, 1'b0);

    // R3
    gc_en = 1'b1; one7("R3", 8'h00, 1'b1, 1'b1);
    gc_en = 1'b0; one7("R3", 8'h00, 1'b0, 1'b0);

    // R5
    load(8'hFF, 5'b00001);
    one7("R5", 8'hA6, 1'b1, 1'b0);
    one7("R5", 8'hA0, 1'b0, 1'b0);
    load(8'hFF, 5'b00010);
    one7("R5", 8'hA0, 1'b1, 1'b0);
    one7("R5", 8'hA6, 1'b0, 1'b0);

    // R4
    mask_mode = 1'b1;
    load(8'h01, 5'h1F);
    one7("R4", 8'hA6, 1'b0, 1'b0);
    one7("R4", 8'hA5, 1'b1, 1'b0);
    load(8'h80, 5'h00);
    one7("R4", 8'h24, 1'b1, 1'b0);

    // R9: repeated START without STOP
    load(8'h00, 5'h00);
    start_c();
    send(8'h50, a);
    chk("R9", "ack before restart", 32'(a), 0);
    start_c();
    send(8'hA4, a);
    chk("R9", "ack after restart", 32'(a), 1);
    chk("R9", "match after restart", 32'(match), 1);
    stop_c();
    chk("R1", "match cleared by STOP", 32'(match), 0);

    // R1: bits without START are ignored
    scl_m = 1'b0; w(Q);
    send(8'hA4, a);
    chk("R1", "ack without START", 32'(a), 0);
    chk("R1", "match without START", 32'(match), 0);
    stop_c();

    // R6, R8, R12: 10-bit
    addr10 = 1'b1; mask_mode = 1'b0; own_addr = 10'h2A5;
    load(8'hFF, 5'b00001);
    irq_cnt = 0;
    start_c();
    send(8'hF4, a);
    chk("R8", "first byte ack", 32'(a), 1);
    chk("R8", "no match after first byte", 32'(match), 0);
    send(8'hA6, a);
    chk("R6", "second byte ack masked 1:0", 32'(a), 1);
    chk("R8", "match after second byte", 32'(match), 1);
    start_c();
    send(8'hF5, a);
    chk("R12", "read form ack", 32'(a), 1);
    chk("R12", "read match", 32'(match), 1);
    chk("R12", "read rw", 32'(rw), 1);
    chk("R11", "irq count", 32'(irq_cnt), 2);
    stop_c();
    start_c();
    send(8'hF5, a);
    chk("R12", "read form after STOP", 32'(a), 0);
    stop_c();
    load(8'hFF, 5'b00000);
    start_c();
    send(8'hF4, a);
    send(8'hA6, a);
    chk("R6", "second byte unmasked", 32'(a), 0);
    chk("R6", "no match unmasked", 32'(match), 0);
    stop_c();
    start_c();
    send(8'hF2, a);
    chk("R8", "wrong high bits", 32'(a), 0);
    stop_c();

    // R10: stretch
    addr10 = 1'b0; mask_mode = 1'b1; own_addr = 10'h0A4; stretch_en = 1'b1;
    load(8'h00, 5'h00);
    start_c();
    send(8'hA4, a);
    chk("R10", "hold asserted", 32'(scl_low), 1);
    w(20);
    chk("R10", "SCL line held", 32'(scl_line), 0);
    hold_release = 1'b1; w(1); hold_release = 1'b0; w(2);
    chk("R10", "hold released", 32'(scl_low), 0);
    stop_c();
    start_c();
    send(8'h50, a);
    w(10);
    chk("R10", "no hold on miss", 32'(scl_low), 0);
    stop_c();
    stretch_en = 1'b0;
    start_c();
    send(8'hA4, a);
    w(10);
    chk("R10", "no hold when disabled", 32'(scl_low), 0);
    stop_c();

    // random 7-bit (R2 R4 R5 R3)
    for (int i = 0; i < 60; i++) begin
      mask_mode = 1'($urandom);
      gc_en     = 1'($urandom);
      own_addr  = 10'($urandom);
      load(8'($urandom & $urandom), 5'($urandom & $urandom));
      ig   = ign_f(mask_mode, 1'b0, cur_mf, cur_mc);
      flip = 8'($urandom & $urandom & $urandom);
      b    = (i % 15 == 0) ? 8'h00 : ({own_addr[7:1], 1'b0} ^ flip);
      one7(mask_mode ? "R4" : "R5", b, e_ack7(b, own_addr, ig, gc_en), (b == 8'h00) && gc_en);
    end

    // random 10-bit (R6 R8)
    addr10 = 1'b1; gc_en = 1'b0;
    for (int i = 0; i < 30; i++) begin
      mask_mode = 1'($urandom);
      own_addr  = 10'($urandom);
      load(8'($urandom & $urandom), 5'($urandom & $urandom));
      ig = ign_f(mask_mode, 1'b1, cur_mf, cur_mc);
      hf = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      b  = {5'b11110, own_addr[9:8] ^ hf, 1'b0};
      start_c();
      send(b, a);
      chk("R8", "random first byte", 32'(a), 32'(hf == 2'b00));
      if (a) begin
        flip = 8'($urandom & $urandom & $urandom);
        b2 = own_addr[7:0] ^ flip;
        send(b2, a);
        chk("R6", "random second byte", 32'(a), 32'(((b2 ^ own_addr[7:0]) & ~ig[7:0]) == 8'd0));
        chk("R8", "random match", 32'(match), 32'(a));
      end
      stop_c();
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule